// File: doc/BRIEF.md
# Chip-Select Bus Cycle Terminator

This block sits beside an asynchronous external bus master. On every clock it samples the address strobe, data strobe, read/write direction, the 3-bit function code and the address. It then produces a chip-select for one programmable address region, and the data-size acknowledge code that ends the current bus cycle. One option word programs the region and the cycle timing:

- a base and a mask;
- a 4-bit acknowledge field, which selects wait states, fast termination or no internal acknowledge;
- a strobe-select bit;
- a port-width bit.

An acknowledge code driven from outside the block always ends the cycle, whatever the option field holds.

When the function code marks the special control space, the block does not try to match the region. It classifies the cycle from the top four address bits as one of three supported control cycles, and reports the type one-hot. An unsupported type gets a one-clock flag and no internal acknowledge. The outputs are registered. The chip-select and acknowledge are also forced inactive as soon as the address strobe drops, so nothing leaks into the next cycle.

Top module: `cs_cycle_term`

## Requirements
- R1: While reset is high and at the first edge after it, cs_o is 0, ack_o is 11, cpu_type_o is 000 and bad_type_o is 0.
- R2: After a rising edge at which as_i=1, fc_i!=7 and (addr_i & opt_mask_i)==(opt_base_i & opt_mask_i), cs_o is 1 when opt_strobe_as_i=1. When opt_strobe_as_i=0, cs_o is 1 only if ds_i was 1 at that edge; in fast mode, writes (rd_i=0) never get a chip-select with this strobe setting.
- R3: With opt_ack_i=1110 in a matching cycle, the internal acknowledge appears after the second rising edge at which as_i is high.
- R4: With opt_ack_i=n, for n from 0 to 13, in a matching cycle, the internal acknowledge appears after edge n+3 of the cycle.
- R5: With opt_ack_i=1111, no internal acknowledge is ever produced; ack_o stays 11 unless an external code arrives.
- R6: An ext_ack_i value other than 11, sampled at an edge while as_i=1, appears on ack_o after that edge and overrides the internal acknowledge for the rest of the cycle, in any mode and even without a region match.
- R7: When as_i is 0, ack_o is 11 and cs_o is 0 at once, with no clock edge needed.
- R8: The internal acknowledge code is 01 (16-bit port) when opt_port16_i=1 and 00 (8-bit port) otherwise. A non-control cycle that misses the region gets no internal acknowledge.
- R9: After an edge with as_i=1 and fc_i=7, cpu_type_o has bit0 set for type 0 (breakpoint), bit1 for type 3 (low-power stop) or bit2 for type F (interrupt acknowledge), taken from addr_i[19:16]. Otherwise it is 000, and fc_i has no effect while as_i=0.
- R10: A control cycle with any other type code pulses bad_type_o for exactly the clock after the first edge of the cycle and gets no internal acknowledge. Supported control cycles get a 01 acknowledge after edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| as_i | input | 1 | Address strobe, active high |
| ds_i | input | 1 | Data strobe, active high |
| rd_i | input | 1 | 1 = read, 0 = write |
| fc_i | input | 3 | Function code; 7 = control space |
| addr_i | input | ADDR_W (20) | Bus address |
| ext_ack_i | input | 2 | External acknowledge code, 11 = none |
| opt_base_i | input | ADDR_W | Region base |
| opt_mask_i | input | ADDR_W | Region compare mask |
| opt_ack_i | input | 4 | 0-13 wait states, 1110 fast, 1111 off |
| opt_strobe_as_i | input | 1 | 1 = qualify by address strobe, 0 = by data strobe |
| opt_port16_i | input | 1 | Port width for internal acknowledge |
| cs_o | output | 1 | Chip-select, active high |
| ack_o | output | 2 | Acknowledge code, 11 = none |
| cpu_type_o | output | 3 | One-hot control cycle type |
| bad_type_o | output | 1 | Unsupported control type pulse |

## Verification
The hardest state to reach is an external acknowledge that lands in the middle of a long internal wait, in a cycle that may also miss the region or sit in control space. The random stimulus draws each cycle's length, wait code, region hit, function code and the edge at which an external code is applied, all independently. Directed cycles add the thirteen-wait-state extreme, fast writes under each strobe setting, and control-space strobes on an idle bus.

// File: rtl/csct_pkg.sv
package csct_pkg;
  localparam logic [1:0] ACK_NONE = 2'b11;
  localparam logic [1:0] ACK_B8   = 2'b00;
  localparam logic [1:0] ACK_B16  = 2'b01;
  localparam logic [2:0] FC_CPU   = 3'd7;
  localparam int         N_TYPES  = 3;

  // control cycle type codes, index i maps to one-hot bit i
  function automatic logic [3:0] type_code(input int idx);
    case (idx)
      0:       return 4'h0;
      1:       return 4'h3;
      default: return 4'hF;
    endcase
  endfunction
endpackage

// File: rtl/csct_wait_cnt.sv
module csct_wait_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             as_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || !as_i) cnt_o <= '0;
    else if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/csct_decode.sv
module csct_decode
  import csct_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        fc_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] mask_i,
  output logic              cpu_space_o,
  output logic              match_o,
  output logic [N_TYPES-1:0] type_oh_o,
  output logic              unsup_o
);
  localparam int TOP = ADDR_W - 1;

  logic [3:0] tcode;
  assign tcode       = addr_i[TOP -: 4];
  assign cpu_space_o = (fc_i == FC_CPU);
  assign match_o     = !cpu_space_o && ((addr_i & mask_i) == (base_i & mask_i));

  for (genvar i = 0; i < N_TYPES; i++) begin : g_type
    assign type_oh_o[i] = cpu_space_o && (tcode == type_code(i));
  end

  assign unsup_o = cpu_space_o && (type_oh_o == '0);
endmodule

// File: rtl/csct_ack.sv
module csct_ack
  import csct_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int OPT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             as_i,
  input  logic [1:0]       ext_ack_i,
  input  logic [OPT_W-1:0] opt_ack_i,
  input  logic             port16_i,
  input  logic             match_i,
  input  logic             cpu_ok_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [1:0]       ack_o
);
  localparam logic [OPT_W-1:0] OPT_OFF  = '1;
  localparam logic [OPT_W-1:0] OPT_FAST = OPT_OFF - 1'b1;
  localparam int               ZERO_WS  = 2;

  logic [1:0]       ack_q;
  logic             int_due;
  logic [CNT_W:0]   thresh;

  always_comb begin
    thresh  = {1'b0, opt_ack_i} + (CNT_W+1)'(ZERO_WS);
    int_due = 1'b0;
    if (cpu_ok_i)
      int_due = ({1'b0, cnt_i} >= (CNT_W+1)'(ZERO_WS));
    else if (match_i && opt_ack_i == OPT_FAST)
      int_due = (cnt_i >= CNT_W'(1));
    else if (match_i && opt_ack_i != OPT_OFF)
      int_due = ({1'b0, cnt_i} >= thresh);
  end

  always_ff @(posedge clk) begin
    if (rst || !as_i)              ack_q <= ACK_NONE;
    else if (ext_ack_i != ACK_NONE) ack_q <= ext_ack_i;
    else if (ack_q != ACK_NONE)    ack_q <= ack_q;
    else if (int_due)              ack_q <= (port16_i || cpu_ok_i) ? ACK_B16 : ACK_B8;
  end

  // drop at once when the strobe falls
  assign ack_o = as_i ? ack_q : ACK_NONE;

  a_r6_ext_wins: assert property (@(posedge clk) disable iff (rst)
    (as_i && ext_ack_i != ACK_NONE) |=> (ack_q == $past(ext_ack_i)));

  a_r3_fast_timing: assert property (@(posedge clk) disable iff (rst)
    ($rose(ack_q != ACK_NONE) && $past(ext_ack_i) == ACK_NONE &&
     $past(opt_ack_i) == OPT_FAST && $past(match_i)) |-> ($past(cnt_i) >= CNT_W'(1)));

  a_r5_off_silent: assert property (@(posedge clk) disable iff (rst)
    ($rose(ack_q != ACK_NONE) && $past(opt_ack_i) == OPT_OFF && !$past(cpu_ok_i))
      |-> ($past(ext_ack_i) != ACK_NONE));
endmodule

// File: rtl/cs_cycle_term.sv
module cs_cycle_term
  import csct_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int OPT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              as_i,
  input  logic              ds_i,
  input  logic              rd_i,
  input  logic [2:0]        fc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        ext_ack_i,
  input  logic [ADDR_W-1:0] opt_base_i,
  input  logic [ADDR_W-1:0] opt_mask_i,
  input  logic [OPT_W-1:0]  opt_ack_i,
  input  logic              opt_strobe_as_i,
  input  logic              opt_port16_i,
  output logic              cs_o,
  output logic [1:0]        ack_o,
  output logic [2:0]        cpu_type_o,
  output logic              bad_type_o
);
  localparam int CNT_W = OPT_W;
  localparam logic [OPT_W-1:0] OPT_FAST = {{(OPT_W-1){1'b1}}, 1'b0};

  logic [CNT_W-1:0]   cnt;
  logic               cpu_space, match, unsup;
  logic [N_TYPES-1:0] type_oh;
  logic               cs_q, cs_next, fast_wr;
  logic [N_TYPES-1:0] type_q;
  logic               bad_q;

  csct_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .as_i(as_i), .cnt_o(cnt)
  );

  csct_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(addr_i), .fc_i(fc_i), .base_i(opt_base_i), .mask_i(opt_mask_i),
    .cpu_space_o(cpu_space), .match_o(match), .type_oh_o(type_oh), .unsup_o(unsup)
  );

  csct_ack #(.CNT_W(CNT_W), .OPT_W(OPT_W)) u_ack (
    .clk(clk), .rst(rst), .as_i(as_i), .ext_ack_i(ext_ack_i),
    .opt_ack_i(opt_ack_i), .port16_i(opt_port16_i), .match_i(match),
    .cpu_ok_i(cpu_space && !unsup), .cnt_i(cnt), .ack_o(ack_o)
  );

  assign fast_wr = (opt_ack_i == OPT_FAST) && !rd_i;
  assign cs_next = as_i && match && (opt_strobe_as_i || (ds_i && !fast_wr));

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b0;
      type_q <= '0;
      bad_q  <= 1'b0;
    end else begin
      cs_q   <= cs_next;
      type_q <= as_i ? type_oh : '0;
      bad_q  <= as_i && (cnt == '0) && unsup;
    end
  end

  assign cs_o       = cs_q && as_i;
  assign cpu_type_o = type_q;
  assign bad_type_o = bad_q;

  a_r9_type_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cpu_type_o));

  a_r10_bad_no_type: assert property (@(posedge clk) disable iff (rst)
    bad_type_o |-> (cpu_type_o == '0));

  a_r10_bad_pulse: assert property (@(posedge clk) disable iff (rst)
    bad_type_o |=> !bad_type_o);

  a_r2_cs_not_cpu: assert property (@(posedge clk) disable iff (rst)
    cs_q |-> ($past(fc_i) != FC_CPU));
endmodule

// File: tb/cs_cycle_term_bench.sv
module cs_cycle_term_bench;
  localparam int AW = 20;

  logic clk = 0, rst = 1;
  logic as_i = 0, ds_i = 0, rd_i = 0, opt_strobe_as_i = 0, opt_port16_i = 0;
  logic [2:0] fc_i = 0;
  logic [AW-1:0] addr_i = 0, opt_base_i = 0, opt_mask_i = 0;
  logic [1:0] ext_ack_i = 2'b11;
  logic [3:0] opt_ack_i = 0;
  logic cs_o, bad_type_o;
  logic [1:0] ack_o;
  logic [2:0] cpu_type_o;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cs_cycle_term u_cs_cycle_term (
    .clk(clk), .rst(rst), .as_i(as_i), .ds_i(ds_i), .rd_i(rd_i), .fc_i(fc_i),
    .addr_i(addr_i), .ext_ack_i(ext_ack_i), .opt_base_i(opt_base_i),
    .opt_mask_i(opt_mask_i), .opt_ack_i(opt_ack_i),
    .opt_strobe_as_i(opt_strobe_as_i), .opt_port16_i(opt_port16_i),
    .cs_o(cs_o), .ack_o(ack_o), .cpu_type_o(cpu_type_o), .bad_type_o(bad_type_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit is_cpu(input logic [2:0] fc); return fc == 3'd7; endfunction
  function automatic bit is_match(input logic [2:0] fc, input logic [AW-1:0] a, b, m);
    return !is_cpu(fc) && ((a & m) == (b & m));
  endfunction
  function automatic logic [2:0] exp_type(input logic [2:0] fc, input logic [AW-1:0] a);
    if (!is_cpu(fc)) return 3'b000;
    case (a[19:16])
      4'h0: return 3'b001;
      4'h3: return 3'b010;
      4'hF: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction
  // edge index at which internal ack is first visible, 0 = never
  function automatic int ack_edge(input logic [2:0] fc, input logic [AW-1:0] a, b, m,
                                  input logic [3:0] opt);
    if (is_cpu(fc)) return (exp_type(fc, a) != 0) ? 3 : 0;
    if (!is_match(fc, a, b, m)) return 0;
    if (opt == 4'hE) return 2;
    if (opt == 4'hF) return 0;
    return int'(opt) + 3;
  endfunction

  // one bus cycle of len edges; external code applied before edge ext_at (0 = never)
  task automatic bus_cycle(input logic [2:0] fc, input logic [AW-1:0] a, input bit rd,
                           input bit ds, input int len, input int ext_at,
                           input logic [1:0] ext_code);
    int te;
    bit m, cs_exp;
    logic [1:0] int_code, e;
    te = ack_edge(fc, a, opt_base_i, opt_mask_i, opt_ack_i);
    m  = is_match(fc, a, opt_base_i, opt_mask_i);
    cs_exp = m && (opt_strobe_as_i || (ds && !(opt_ack_i == 4'hE && !rd)));
    int_code = (is_cpu(fc) || opt_port16_i) ? 2'b01 : 2'b00;
    @(negedge clk);
    fc_i = fc; addr_i = a; rd_i = rd; ds_i = ds; as_i = 1;
    ext_ack_i = (ext_at == 1) ? ext_code : 2'b11;
    for (int k = 1; k <= len; k++) begin
      @(posedge clk); #2;
      if (ext_at != 0 && k >= ext_at) e = ext_code;
      else if (te != 0 && k >= te) e = int_code;
      else e = 2'b11;
      chk((ext_at != 0 && k >= ext_at) ? "R6 ext ack" :
          (opt_ack_i == 4'hE ? "R3 fast ack" : "R4/R5/R8/R10 ack"), ack_o, e);
      chk("R2 cs", cs_o, cs_exp);
      chk("R9 type", cpu_type_o, exp_type(fc, a));
      chk("R10 bad", bad_type_o, (is_cpu(fc) && exp_type(fc, a) == 0 && k == 1));
      @(negedge clk);
      if (ext_at != 0 && k + 1 >= ext_at) ext_ack_i = ext_code;
    end
    as_i = 0; ds_i = 0; ext_ack_i = 2'b11;
    #1;
    chk("R7 ack idle", ack_o, 2'b11);
    chk("R7 cs idle", cs_o, 0);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    logic [AW-1:0] a;
    logic [2:0] fc;
    int len, ext_at;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset ack", ack_o, 2'b11);
    chk("R1 reset cs", cs_o, 0);
    chk("R1 reset type", cpu_type_o, 0);
    chk("R1 reset bad", bad_type_o, 0);
    @(negedge clk); rst = 0;
    @(posedge clk); #2;
    chk("R1 after reset ack", ack_o, 2'b11);

    opt_base_i = 20'h4_0000; opt_mask_i = 20'hF_0000; opt_port16_i = 1;
    // R3 fast read, data strobe qualified
    opt_ack_i = 4'hE; opt_strobe_as_i = 0;
    bus_cycle(3'd5, 20'h4_1234, 1, 1, 4, 0, 2'b11);
    // R2 fast write with data strobe select: no cs
    bus_cycle(3'd5, 20'h4_0010, 0, 1, 4, 0, 2'b11);
    // R2 fast write with address strobe select: cs
    opt_strobe_as_i = 1;
    bus_cycle(3'd5, 20'h4_0010, 0, 0, 4, 0, 2'b11);
    // R4 thirteen wait states, 8-bit port (R8)
    opt_ack_i = 4'd13; opt_port16_i = 0;
    bus_cycle(3'd1, 20'h4_0002, 1, 1, 18, 0, 2'b11);
    // R4 zero wait states
    opt_ack_i = 4'd0;
    bus_cycle(3'd1, 20'h4_0002, 1, 1, 5, 0, 2'b11);
    // R8 region miss: no ack
    bus_cycle(3'd1, 20'h5_0002, 1, 1, 6, 0, 2'b11);
    // R5 internal off, then R6 external in middle of a missed region
    opt_ack_i = 4'hF;
    bus_cycle(3'd1, 20'h4_0002, 1, 1, 8, 0, 2'b11);
    bus_cycle(3'd1, 20'h6_0002, 1, 1, 8, 4, 2'b00);
    // R6 external while internal wait pending
    opt_ack_i = 4'd10;
    bus_cycle(3'd2, 20'h4_0000, 1, 1, 8, 2, 2'b01);
    // R9 each control type, R10 unsupported
    bus_cycle(3'd7, 20'h0_0000, 1, 1, 4, 0, 2'b11);
    bus_cycle(3'd7, 20'h3_0000, 1, 1, 4, 0, 2'b11);
    bus_cycle(3'd7, 20'hF_0000, 1, 1, 4, 0, 2'b11);
    bus_cycle(3'd7, 20'h5_0000, 1, 1, 4, 0, 2'b11);
    // R9 fc ignored while strobe low
    @(negedge clk); fc_i = 3'd7; addr_i = 20'h0_0000;
    @(posedge clk); #2;
    chk("R9 idle fc ignored", cpu_type_o, 0);
    chk("R10 idle no bad", bad_type_o, 0);

    for (int n = 0; n < 400; n++) begin
      opt_ack_i       = 4'($urandom_range(0, 15));
      opt_strobe_as_i = 1'($urandom_range(0, 1));
      opt_port16_i    = 1'($urandom_range(0, 1));
      opt_mask_i      = 20'($urandom) & 20'hF00FF;
      opt_base_i      = 20'($urandom);
      fc   = ($urandom_range(0, 4) == 0) ? 3'd7 : 3'($urandom_range(0, 6));
      a    = ($urandom_range(0, 1) == 1) ? (opt_base_i ^ (20'($urandom) & ~opt_mask_i))
                                         : 20'($urandom);
      if (fc == 3'd7 && $urandom_range(0, 1) == 1)
        a[19:16] = ($urandom_range(0, 2) == 0) ? 4'h0 : (($urandom_range(0, 1) == 1) ? 4'h3 : 4'hF);
      len    = $urandom_range(1, 18);
      ext_at = ($urandom_range(0, 2) == 0) ? $urandom_range(1, 18) : 0;
      bus_cycle(fc, a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), len, ext_at,
                2'($urandom_range(0, 1)));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule